// File: doc/BRIEF.md
# Memory-Mapped Serial Port

The block is a byte-wide asynchronous serial port on a 32-bit register port. Four registers sit at word offsets 0x0, 0x4, 0x8 and 0xC of a byte address. Software writes a byte to the transmit register and polls a transmitter-free flag. It sets a receive-enable bit, then polls a byte-waiting flag and reads the received byte. The line format is one start bit (low), eight data bits with the least significant bit first, and one stop bit (high). Both directions hold one byte at most.

Bit timing does not come from an integer divider. Each direction runs a 32-bit phase accumulator, and the bit boundary is the carry out of that accumulator. The per-clock increment lives in the register at offset 0x0. It resets to round(2^32 × BAUD / CLK_HZ), which by default is 115200 baud from a 100 MHz clock. The transmitter clears its accumulator when a frame starts. The receiver preloads its accumulator to half scale when it sees a falling edge, so every carry lands in the middle of a bit.

The bus side takes a one-cycle request and acknowledges it with a one-cycle pulse on the next clock. Read data is valid together with that pulse. Write effects take place at the clock edge that samples the request.

Top module: `mmio_serial_port`

## Requirements
- R1: After reset the tx line is high, the flags register reads 0x0000_0010 and the increment register reads round(2^32 × BAUD / CLK_HZ).
- R2: The increment register at offset 0x0 is read/write, and each byte lane is written only when its byte enable is set.
- R3: A write to offset 0x8 with byte enable 0 set sends bits 7:0 of the written word as a frame: start low, data LSB first, stop high. Each bit lasts 2^32/increment clocks.
- R4: Flags bit 4 is 1 exactly while the transmitter is free. It drops after an accepted write and returns after the stop bit. A transmit write while the transmitter is busy is ignored.
- R5: When a frame with a high stop bit is received, flags bit 0 becomes 1 and a read of offset 0xC returns the byte in bits 7:0 with bits 31:8 zero.
- R6: A read of offset 0xC clears flags bit 0.
- R7: Flags bit 8 is the read/write receive enable, written through byte lane 1 of offset 0x4, and it resets to 0. While it is 0, incoming frames set no flag and change no stored byte.
- R8: The receiver samples each bit in its middle and drops a frame whose stop bit is low: flags bit 0 stays 0.
- R9: Every request is acknowledged by bus_ack high for exactly the one cycle that follows it.
- R10: The tx line stays high whenever no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Acknowledge, one cycle after the request |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| ser_tx_o | output | 1 | Serial transmit line |
| ser_rx_i | input | 1 | Serial receive line (asynchronous) |

## Verification
The bench runs with 16 clocks per bit, so every result has a known due time.

- **Bus:** the acknowledge and the read data are sampled at the first falling edge after the request edge.
- **Transmit:** the bench waits for the first low level on the tx line, then samples each of the ten bits about 6 to 8 clocks into it. The transmitter-free flag is read at least 10 clocks after the mid-stop sample.
- **Receive:** the flag is set about 155 clocks after the start edge, because of the two-flop synchronizer, a half bit and nine full bits. The bench reads flags 4 clocks after the 160-clock frame ends. For ignored frames it also reads back the stored byte.

// File: rtl/ser_pkg.sv
package ser_pkg;
   localparam int REG_W      = 32;
   localparam int BYTE_W     = 8;
   localparam int LANES      = REG_W / BYTE_W;
   localparam int ADDR_W     = 4;
   localparam int DATA_BITS  = 8;
   localparam int CNT_W      = 4;

   // Register select values (bus_addr[3:2])
   localparam logic [1:0] SEL_INC  = 2'd0;
   localparam logic [1:0] SEL_FLG  = 2'd1;
   localparam logic [1:0] SEL_TXD  = 2'd2;
   localparam logic [1:0] SEL_RXD  = 2'd3;

   // Flag bit positions
   localparam int FLG_RX_RDY = 0;
   localparam int FLG_TX_RDY = 4;
   localparam int FLG_RX_EN  = 8;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

   function automatic logic [31:0] calc_inc(input int unsigned clk_hz,
                                            input int unsigned baud);
      longint unsigned num;
      num = (longint'(baud) << 32) + longint'(clk_hz / 2);
      return 32'(num / longint'(clk_hz));
   endfunction
endpackage

// File: rtl/ser_phase_acc.sv
module ser_phase_acc #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         run_i,
   input  logic [W-1:0] inc_i,
   output logic         tick_o
);
   logic [W-1:0] phase_q;
   logic [W:0]   sum;

   assign sum    = {1'b0, phase_q} + {1'b0, inc_i};
   assign tick_o = run_i & ~load_i & sum[W];

   always_ff @(posedge clk) begin
      if (!rst_n)      phase_q <= '0;
      else if (load_i) phase_q <= load_val_i;
      else if (run_i)  phase_q <= sum[W-1:0];
   end

   // A freshly loaded accumulator cannot produce a tick on the next cycle
   // unless the increment alone reaches the carry (R3 bit length)
   p_no_early_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && load_val_i == '0 && inc_i < {1'b1, {(W-1){1'b0}}}) |=> !tick_o);
endmodule

// File: rtl/ser_tx.sv
module ser_tx import ser_pkg::*; #(
   parameter int ACC_W = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic             ack_o,
   input  logic [ACC_W-1:0] inc_i,
   output logic             tx_o
);
   localparam int LAST_IDX = DATA_BITS + 1;

   logic                 busy_q;
   logic [DATA_BITS:0]   shreg_q;
   logic [CNT_W-1:0]     cnt_q;
   logic                 take;
   logic                 tick;

   assign ack_o = ~busy_q;
   assign take  = stb_i & ~busy_q;

   ser_phase_acc #(.W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .load_i(take), .load_val_i('0),
      .run_i(busy_q), .inc_i(inc_i), .tick_o(tick));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         shreg_q <= '1;
         cnt_q   <= '0;
         tx_o    <= 1'b1;
      end else if (take) begin
         busy_q  <= 1'b1;
         shreg_q <= {1'b1, data_i};
         cnt_q   <= '0;
         tx_o    <= 1'b0;
      end else if (busy_q && tick) begin
         if (cnt_q == CNT_W'(LAST_IDX)) begin
            busy_q <= 1'b0;
            tx_o   <= 1'b1;
         end else begin
            tx_o    <= shreg_q[0];
            shreg_q <= {1'b1, shreg_q[DATA_BITS:1]};
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> tx_o);
   p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !tx_o);
endmodule

// File: rtl/ser_rx.sv
module ser_rx import ser_pkg::*; #(
   parameter int ACC_W       = 32,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [ACC_W-1:0]  inc_i,
   input  logic              rx_i,
   output logic              done_o,
   output logic [BYTE_W-1:0] byte_o
);
   localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

   logic                 rxd;
   rx_state_t            st_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [BYTE_W-1:0]    shreg_q;
   logic                 tick;
   logic                 arm;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxd = rx_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[s] <= 1'b1;
               else        sync_q[s] <= (s == 0) ? rx_i : sync_q[(s == 0) ? 0 : s-1];
            end
         end
         assign rxd = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   assign arm = en_i & (st_q == RX_IDLE) & ~rxd;

   ser_phase_acc #(.W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .load_i(arm), .load_val_i(HALF),
      .run_i(st_q != RX_IDLE), .inc_i(inc_i), .tick_o(tick));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= RX_IDLE;
         cnt_q   <= '0;
         shreg_q <= '0;
         done_o  <= 1'b0;
         byte_o  <= '0;
      end else begin
         done_o <= 1'b0;
         if (!en_i) begin
            st_q <= RX_IDLE;
         end else begin
            case (st_q)
               RX_IDLE:  if (!rxd) st_q <= RX_START;
               RX_START: if (tick) begin
                  st_q  <= rxd ? RX_IDLE : RX_DATA;
                  cnt_q <= '0;
               end
               RX_DATA:  if (tick) begin
                  shreg_q <= {rxd, shreg_q[BYTE_W-1:1]};
                  if (cnt_q == CNT_W'(DATA_BITS - 1)) st_q <= RX_STOP;
                  else cnt_q <= cnt_q + 1'b1;
               end
               RX_STOP:  if (tick) begin
                  st_q <= RX_IDLE;
                  if (rxd) begin
                     done_o <= 1'b1;
                     byte_o <= shreg_q;
                  end
               end
               default:  st_q <= RX_IDLE;
            endcase
         end
      end
   end

   p_bad_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && st_q == RX_STOP && tick && !rxd) |=> !done_o);
   p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !done_o);
endmodule

// File: rtl/mmio_serial_port.sv
module mmio_serial_port import ser_pkg::*; #(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned BAUD        = 115_200,
   parameter int          SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [LANES-1:0]  bus_be,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic              bus_ack,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              ser_tx_o,
   input  logic              ser_rx_i
);
   localparam logic [REG_W-1:0] INC_RST = calc_inc(CLK_HZ, BAUD);

   generate
      if (longint'(BAUD) * 2 > longint'(CLK_HZ)) begin : g_bad_rate
         $error("BAUD must be at most half of CLK_HZ");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
      if (INC_RST == '0) begin : g_bad_inc
         $error("derived increment is zero");
      end
   endgenerate

   logic [REG_W-1:0]  inc_q;
   logic              rx_en_q;
   logic              rx_rdy_q;
   logic [BYTE_W-1:0] rx_byte;
   logic              rx_done;
   logic              tx_free;
   logic              tx_stb;
   logic              wr, rd;
   logic [1:0]        sel;
   logic              rd_rx;
   logic [REG_W-1:0]  rd_mux;

   assign sel   = bus_addr[3:2];
   assign wr    = bus_req &  bus_we;
   assign rd    = bus_req & ~bus_we;
   assign rd_rx = rd && sel == SEL_RXD;
   assign tx_stb = wr && sel == SEL_TXD && bus_be[0];

   // Increment register, one generate branch per byte lane
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n)
               inc_q[l*BYTE_W +: BYTE_W] <= INC_RST[l*BYTE_W +: BYTE_W];
            else if (wr && sel == SEL_INC && bus_be[l])
               inc_q[l*BYTE_W +: BYTE_W] <= bus_wdata[l*BYTE_W +: BYTE_W];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_en_q  <= 1'b0;
         rx_rdy_q <= 1'b0;
      end else begin
         if (wr && sel == SEL_FLG && bus_be[FLG_RX_EN / BYTE_W])
            rx_en_q <= bus_wdata[FLG_RX_EN];
         if (rx_done)    rx_rdy_q <= 1'b1;
         else if (rd_rx) rx_rdy_q <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_INC: rd_mux = inc_q;
         SEL_FLG: begin
            rd_mux[FLG_RX_RDY] = rx_rdy_q;
            rd_mux[FLG_TX_RDY] = tx_free;
            rd_mux[FLG_RX_EN]  = rx_en_q;
         end
         SEL_RXD: rd_mux[BYTE_W-1:0] = rx_byte;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ack <= bus_req;
         if (rd) bus_rdata <= rd_mux;
      end
   end

   ser_tx #(.ACC_W(REG_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .stb_i(tx_stb), .data_i(bus_wdata[BYTE_W-1:0]),
      .ack_o(tx_free), .inc_i(inc_q), .tx_o(ser_tx_o));

   ser_rx #(.ACC_W(REG_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .en_i(rx_en_q), .inc_i(inc_q),
      .rx_i(ser_rx_i), .done_o(rx_done), .byte_o(rx_byte));

   p_ack_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> bus_ack);
   p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |=> !bus_ack);
   p_rdy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx && !rx_done) |=> !rx_rdy_q);
   p_tx_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_stb && tx_free) |=> !tx_free);
   p_rx_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en_q && !rx_rdy_q) |=> !rx_rdy_q);
endmodule

// File: tb/mmio_serial_port_tb_top.sv
module mmio_serial_port_tb_top;
   localparam int unsigned CLK_HZ = 50_000_000;
   localparam int unsigned BAUD   = 3_125_000;
   localparam int BIT_CLKS        = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_addr = '0, bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ack;
   logic [31:0] bus_rdata;
   logic        ser_tx_o;
   logic        ser_rx_i = 1'b1;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   mmio_serial_port #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .ser_tx_o(ser_tx_o), .ser_rx_i(ser_rx_i));

   function automatic logic [31:0] exp_inc(input int unsigned c, input int unsigned b);
      longint unsigned n;
      n = (longint'(b) << 32) + longint'(c / 2);
      return 32'(n / longint'(c));
   endfunction

   function automatic logic [31:0] exp_flags(input bit rdy, input bit txf, input bit en);
      return (32'(rdy) << 0) | (32'(txf) << 4) | (32'(en) << 8);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the falling edge after the acknowledge
   task automatic bus_op(input logic we, input logic [3:0] a, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
      @(negedge clk);
      rd = bus_rdata;
      chk(bus_ack === 1'b1, "R9 ack after request", 32'(bus_ack), 32'd1);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] rd);
      bus_op(1'b0, a, 4'h0, 32'h0, rd);
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [3:0] be, input logic [31:0] wd);
      logic [31:0] dummy;
      bus_op(1'b1, a, be, wd, dummy);
   endtask

   task automatic decode_tx(output logic [7:0] b, output bit frame_ok);
      int guard = 0;
      bit st, sp;
      while (ser_tx_o && guard < 400) begin @(negedge clk); guard++; end
      repeat (6) @(negedge clk);
      st = ser_tx_o;
      for (int k = 0; k < 8; k++) begin
         repeat (BIT_CLKS) @(negedge clk);
         b[k] = ser_tx_o;
      end
      repeat (BIT_CLKS) @(negedge clk);
      sp = ser_tx_o;
      frame_ok = (guard < 400) && !st && sp;
   endtask

   task automatic send_rx(input logic [7:0] b, input bit stop_bit);
      ser_rx_i = 1'b0;
      repeat (BIT_CLKS) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         ser_rx_i = b[k];
         repeat (BIT_CLKS) @(negedge clk);
      end
      ser_rx_i = stop_bit;
      repeat (BIT_CLKS) @(negedge clk);
      ser_rx_i = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      logic [7:0]  b, got, last_rx;
      bit          ok;
      logic [31:0] inc_def;
      void'($urandom(32'd4711));
      inc_def = exp_inc(CLK_HZ, BAUD);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(ser_tx_o === 1'b1, "R1 tx idle after reset", 32'(ser_tx_o), 32'd1);
      rd_reg(4'h4, r);
      chk(r === exp_flags(0, 1, 0), "R1 flags after reset", r, exp_flags(0, 1, 0));
      rd_reg(4'h0, r);
      chk(r === inc_def, "R1 increment reset value", r, inc_def);
      @(negedge clk);
      chk(bus_ack === 1'b0, "R9 ack is a single pulse", 32'(bus_ack), 32'd0);

      // R2 byte-lane writes on the increment register
      wr_reg(4'h0, 4'b0101, 32'hAABB_CCDD);
      rd_reg(4'h0, r);
      chk(r === {inc_def[31:24], 8'hBB, inc_def[15:8], 8'hDD}, "R2 lane enables",
          r, {inc_def[31:24], 8'hBB, inc_def[15:8], 8'hDD});
      wr_reg(4'h0, 4'hF, inc_def);
      rd_reg(4'h0, r);
      chk(r === inc_def, "R2 full write readback", r, inc_def);

      // R3/R4 directed corners then random transmit bytes
      for (int n = 0; n < 6; n++) begin
         b = (n == 0) ? 8'h00 : (n == 1) ? 8'hFF : 8'($urandom);
         wr_reg(4'h8, 4'h1, {24'hDEAD_BE, b});
         rd_reg(4'h4, r);
         chk(r[4] === 1'b0, "R4 tx flag low while busy", 32'(r[4]), 32'd0);
         decode_tx(got, ok);
         chk(ok && got === b, "R3 transmitted frame", {23'h0, ok, got}, {23'h0, 1'b1, b});
         repeat (10) @(negedge clk);
         rd_reg(4'h4, r);
         chk(r[4] === 1'b1, "R4 tx flag back after stop", 32'(r[4]), 32'd1);
      end

      // R4 write while busy ignored; R10 line stays high afterwards
      wr_reg(4'h8, 4'h1, 32'h0000_005A);
      wr_reg(4'h8, 4'h1, 32'h0000_0000);
      decode_tx(got, ok);
      chk(ok && got === 8'h5A, "R4 busy write ignored, first byte sent",
          {23'h0, ok, got}, {23'h0, 1'b1, 8'h5A});
      begin
         bit stayed = 1'b1;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (ser_tx_o !== 1'b1) stayed = 1'b0;
         end
         chk(stayed, "R10 tx idle high, no second frame", 32'(stayed), 32'd1);
      end

      // R7 enable bit read/write
      wr_reg(4'h4, 4'h2, 32'h0000_0100);
      rd_reg(4'h4, r);
      chk(r === exp_flags(0, 1, 1), "R7 enable bit reads back", r, exp_flags(0, 1, 1));

      // R5/R6 receive bytes
      last_rx = 8'h00;
      for (int n = 0; n < 5; n++) begin
         b = (n == 0) ? 8'h01 : (n == 1) ? 8'h80 : 8'($urandom);
         send_rx(b, 1'b1);
         rd_reg(4'h4, r);
         chk(r[0] === 1'b1, "R5 byte-waiting flag set", 32'(r[0]), 32'd1);
         rd_reg(4'hC, r);
         chk(r === {24'h0, b}, "R5 received byte", r, {24'h0, b});
         rd_reg(4'h4, r);
         chk(r[0] === 1'b0, "R6 read clears flag", 32'(r[0]), 32'd0);
         last_rx = b;
      end

      // R8 low stop bit dropped
      send_rx(8'h3C, 1'b0);
      repeat (40) @(negedge clk);
      rd_reg(4'h4, r);
      chk(r[0] === 1'b0, "R8 bad stop dropped", 32'(r[0]), 32'd0);

      // R7 disabled receiver ignores frames
      wr_reg(4'h4, 4'h2, 32'h0000_0000);
      send_rx(8'hC3, 1'b1);
      rd_reg(4'h4, r);
      chk(r === exp_flags(0, 1, 0), "R7 disabled: no flag", r, exp_flags(0, 1, 0));
      rd_reg(4'hC, r);
      chk(r === {24'h0, last_rx}, "R7 disabled: byte unchanged", r, {24'h0, last_rx});

      // R5 again after re-enable
      wr_reg(4'h4, 4'h2, 32'h0000_0100);
      send_rx(8'hA5, 1'b1);
      rd_reg(4'hC, r);
      chk(r === 32'h0000_00A5, "R5 receive after re-enable", r, 32'h0000_00A5);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule